// File: doc/BRIEF.md
# Adjustable-Rate Nanosecond Time Counter

This block keeps a running nanosecond time value for precision time protocol logic. While it runs, every clock adds a programmable nanosecond step to the counter. To trim the frequency, a second step value is used instead of the normal one on every Nth clock. The counter wraps at a programmable period, or at its full width, and the amount past the wrap point is kept so no nanoseconds are lost.

Software controls the block through a small register port. Writes take effect at the clock edge and reads are combinational. A capture command copies the live value into a snapshot register so that software reads a stable time. Software can also load the counter directly. The live value and two single-cycle event pulses are driven out to neighbouring timer logic.

Top module: `ts_counter`

## Requirements
- R1: While control bit 0 (run) is set, the counter increases on every clock by the step it selected; while run is clear, it holds its value.
- R2: The step register holds the normal step in bits 6:0 and the correction step in bits 14:8, and it reads back in the same layout. When the correction period register (address 3) holds N > 0, every Nth counting clock adds the correction step in place of the normal step; N = 0 turns correction off and N = 1 corrects every clock.
- R3: With control bit 5 set and a nonzero period register (address 4), a sum that reaches or passes the period is reduced by the period. With bit 5 clear, the period has no effect and the counter wraps modulo 2^32.
- R4: When control bit 4 is set, wrap_o is high for exactly the one cycle after the update that wrapped. When bit 4 is clear, wrap_o stays low.
- R5: Writing control with bit 11 set copies the live counter into the snapshot at the next edge. Reads of address 1 return that snapshot. Bit 11 reads as 1 for two cycles and then clears by itself.
- R6: A write to address 1 loads the counter with the write data and takes precedence over that clock's increment.
- R7: When control bit 7 is set, ovf_evt_o gives a one-cycle pulse on every wrap. When bit 7 is clear, it stays low.
- R8: A write to the correction period register restarts the correction tick count, so the next correction falls N counting clocks after that write.
- R9: After reset, the counter, every register and both pulses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; one count step per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address: 0 control, 1 counter/snapshot, 2 step, 3 correction period, 4 wrap period |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i |
| count_o | output | 32 | Live counter value |
| wrap_o | output | 1 | Wrap pulse, gated by control bit 4 |
| ovf_evt_o | output | 1 | Overflow event pulse, gated by control bit 7 |

## Verification
The bench places the correction step at the Nth tick and checks N = 1. A design that counted from one, or that did not restart its tick count when the period register is written, would add the correction step one clock early or late, and the expected totals would not match. It also checks the period wrap, the full-width carry and a 31-bit period. A wrong compare width, or subtracting the period from the old value instead of the sum, would give the wrong remainder or miss the wrap. A period that is not ignored while bit 5 is clear would pull the counter back below 100. The bench also tests capture while the counter runs, to catch a snapshot taken one edge late, and a load during counting, to catch a design that lets the increment win.

// File: rtl/ts_cnt_pkg.sv
package ts_cnt_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 3;
  localparam logic [AW-1:0] ADDR_CTRL  = 3'd0;
  localparam logic [AW-1:0] ADDR_COUNT = 3'd1;
  localparam logic [AW-1:0] ADDR_STEP  = 3'd2;
  localparam logic [AW-1:0] ADDR_CORR  = 3'd3;
  localparam logic [AW-1:0] ADDR_PER   = 3'd4;
  localparam int unsigned CTL_RUN  = 0;
  localparam int unsigned CTL_EVT  = 4;
  localparam int unsigned CTL_PRST = 5;
  localparam int unsigned CTL_OVF  = 7;
  localparam int unsigned CTL_CAP  = 11;
  localparam int unsigned STEP_BASE_LSB = 0;
  localparam int unsigned STEP_CORR_LSB = 8;
endpackage

// File: rtl/ts_regs.sv
module ts_regs import ts_cnt_pkg::*; #(
  parameter int unsigned W  = 32,
  parameter int unsigned IW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [W-1:0]  count_i,
  output logic [DW-1:0] rdata_o,
  output logic          run_o,
  output logic          evt_en_o,
  output logic          per_rst_o,
  output logic          ovf_en_o,
  output logic          load_o,
  output logic [W-1:0]  load_val_o,
  output logic [IW-1:0] step_base_o,
  output logic [IW-1:0] step_corr_o,
  output logic [W-1:0]  corr_per_o,
  output logic          corr_wr_o,
  output logic [W-1:0]  period_o
);
  logic          run_q, evt_q, prst_q, ovf_q, cap_q, cap_done_q;
  logic [IW-1:0] base_q, corr_q;
  logic [W-1:0]  corr_per_q, period_q, snap_q;
  logic          ctrl_wr, cap_wr;

  assign ctrl_wr = we_i && (addr_i == ADDR_CTRL);
  assign cap_wr  = ctrl_wr && wdata_i[CTL_CAP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0; evt_q <= 1'b0; prst_q <= 1'b0; ovf_q <= 1'b0;
      base_q <= '0; corr_q <= '0; corr_per_q <= '0; period_q <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        ADDR_CTRL: begin
          run_q  <= wdata_i[CTL_RUN];
          evt_q  <= wdata_i[CTL_EVT];
          prst_q <= wdata_i[CTL_PRST];
          ovf_q  <= wdata_i[CTL_OVF];
        end
        ADDR_STEP: begin
          base_q <= wdata_i[STEP_BASE_LSB +: IW];
          corr_q <= wdata_i[STEP_CORR_LSB +: IW];
        end
        ADDR_CORR: corr_per_q <= wdata_i[W-1:0];
        ADDR_PER:  period_q   <= wdata_i[W-1:0];
        default: ;
      endcase
    end
  end

  // capture: snapshot one edge after the write, flag drops one edge later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= 1'b0; cap_done_q <= 1'b0; snap_q <= '0;
    end else if (cap_wr) begin
      cap_q <= 1'b1; cap_done_q <= 1'b0;
    end else if (cap_done_q) begin
      cap_q <= 1'b0; cap_done_q <= 1'b0;
    end else if (cap_q) begin
      snap_q <= count_i; cap_done_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: begin
        rdata_o[CTL_RUN]  = run_q;
        rdata_o[CTL_EVT]  = evt_q;
        rdata_o[CTL_PRST] = prst_q;
        rdata_o[CTL_OVF]  = ovf_q;
        rdata_o[CTL_CAP]  = cap_q;
      end
      ADDR_COUNT: rdata_o[W-1:0] = snap_q;
      ADDR_STEP: begin
        rdata_o[STEP_BASE_LSB +: IW] = base_q;
        rdata_o[STEP_CORR_LSB +: IW] = corr_q;
      end
      ADDR_CORR: rdata_o[W-1:0] = corr_per_q;
      ADDR_PER:  rdata_o[W-1:0] = period_q;
      default: ;
    endcase
  end

  assign run_o       = run_q;
  assign evt_en_o    = evt_q;
  assign per_rst_o   = prst_q;
  assign ovf_en_o    = ovf_q;
  assign load_o      = we_i && (addr_i == ADDR_COUNT);
  assign load_val_o  = wdata_i[W-1:0];
  assign step_base_o = base_q;
  assign step_corr_o = corr_q;
  assign corr_per_o  = corr_per_q;
  assign corr_wr_o   = we_i && (addr_i == ADDR_CORR);
  assign period_o    = period_q;

  AST_CAP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_done_q && !cap_wr) |=> !cap_q); // R5
  AST_CAP_SNAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_q && !cap_done_q && !cap_wr) |=> (snap_q == $past(count_i))); // R5
endmodule

// File: rtl/ts_corr.sv
module ts_corr #(
  parameter int unsigned W  = 32,
  parameter int unsigned IW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          clr_i,
  input  logic [W-1:0]  per_i,
  input  logic [IW-1:0] base_i,
  input  logic [IW-1:0] corr_i,
  output logic [IW-1:0] step_o
);
  logic [W-1:0] cnt_q;
  logic         on_nth;

  assign on_nth = (per_i != '0) && (cnt_q == per_i - W'(1));
  assign step_o = on_nth ? corr_i : base_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clr_i)                      cnt_q <= '0;
    else if (tick_i && per_i != '0)      cnt_q <= on_nth ? '0 : cnt_q + W'(1);
  end

  AST_CORR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_i != '0) |-> (cnt_q < per_i)); // R2
  AST_CORR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/ts_accum.sv
module ts_accum #(
  parameter int unsigned W  = 32,
  parameter int unsigned IW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          per_rst_i,
  input  logic          evt_en_i,
  input  logic          ovf_en_i,
  input  logic [W-1:0]  period_i,
  input  logic [IW-1:0] step_i,
  input  logic          load_i,
  input  logic [W-1:0]  load_val_i,
  output logic [W-1:0]  count_o,
  output logic          wrap_o,
  output logic          ovf_o
);
  logic [W-1:0] count_q, nxt;
  logic [W:0]   sum;
  logic         wrapped, tick, wrap_q, ovf_q;

  assign tick = run_i && !load_i;

  always_comb begin
    sum = {1'b0, count_q} + (W+1)'(step_i);
    if (per_rst_i && (period_i != '0) && (sum >= {1'b0, period_i})) begin
      nxt     = W'(sum - {1'b0, period_i});
      wrapped = 1'b1;
    end else begin
      nxt     = sum[W-1:0];
      wrapped = sum[W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0; wrap_q <= 1'b0; ovf_q <= 1'b0;
    end else begin
      if (load_i)    count_q <= load_val_i;
      else if (tick) count_q <= nxt;
      wrap_q <= tick && wrapped && evt_en_i;
      ovf_q  <= tick && wrapped && ovf_en_i;
    end
  end

  assign count_o = count_q;
  assign wrap_o  = wrap_q;
  assign ovf_o   = ovf_q;

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> $stable(count_q)); // R1
  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (count_q == $past(load_val_i))); // R6
  AST_WRAP_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_q |-> $past(run_i && evt_en_i)); // R4
  AST_OVF_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> $past(run_i && ovf_en_i)); // R7
endmodule

// File: rtl/ts_counter.sv
module ts_counter import ts_cnt_pkg::*; #(
  parameter int unsigned W  = 32,
  parameter int unsigned IW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [W-1:0]  count_o,
  output logic          wrap_o,
  output logic          ovf_evt_o
);
  logic          run, evt_en, per_rst, ovf_en, load, corr_wr;
  logic [W-1:0]  load_val, corr_per, period;
  logic [IW-1:0] step_base, step_corr, step;

  ts_regs #(.W(W), .IW(IW)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .count_i(count_o), .rdata_o,
    .run_o(run), .evt_en_o(evt_en), .per_rst_o(per_rst), .ovf_en_o(ovf_en),
    .load_o(load), .load_val_o(load_val),
    .step_base_o(step_base), .step_corr_o(step_corr),
    .corr_per_o(corr_per), .corr_wr_o(corr_wr), .period_o(period)
  );

  ts_corr #(.W(W), .IW(IW)) u_corr (
    .clk_i, .rst_ni,
    .tick_i(run && !load), .clr_i(corr_wr), .per_i(corr_per),
    .base_i(step_base), .corr_i(step_corr), .step_o(step)
  );

  ts_accum #(.W(W), .IW(IW)) u_accum (
    .clk_i, .rst_ni,
    .run_i(run), .per_rst_i(per_rst), .evt_en_i(evt_en), .ovf_en_i(ovf_en),
    .period_i(period), .step_i(step), .load_i(load), .load_val_i(load_val),
    .count_o, .wrap_o, .ovf_o(ovf_evt_o)
  );
endmodule

// File: tb/ts_counter_tb_top.sv
`timescale 1ns/1ps
module ts_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, count;
  logic        wrap, ovf;
  int          n_chk = 0;
  int          n_err = 0;

  localparam logic [31:0] RUN = 32'h1, EVT = 32'h10, PRST = 32'h20,
                          OVF = 32'h80, CAP = 32'h800;

  always #10 clk = ~clk;

  ts_counter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .count_o(count), .wrap_o(wrap), .ovf_evt_o(ovf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // called at a negedge; exactly one posedge performs the write
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R9 count", count, 0);
    chk("R9 wrap", {31'b0, wrap}, 0);
    chk("R9 ovf", {31'b0, ovf}, 0);
    rd(0, d); chk("R9 ctrl", d, 0);
    rd(2, d); chk("R9 step", d, 0);
    rd(4, d); chk("R9 period", d, 0);
  endtask

  task automatic t_step_readback;
    logic [31:0] d;
    wr(2, 32'hFFFF_0D0A);
    rd(2, d); chk("R2 step fields", d, 32'h0000_0D0A);
  endtask

  task automatic t_basic;
    wr(3, 0); wr(2, 32'd10); wr(1, 0);
    wr(0, RUN);
    repeat (5) @(negedge clk);
    chk("R1 running", count, 50);
    wr(0, 0);
    chk("R1 stop edge", count, 60);
    repeat (3) @(negedge clk);
    chk("R1 hold", count, 60);
  endtask

  task automatic t_corr;
    wr(2, {17'b0, 7'd13, 1'b0, 7'd10}); wr(3, 3); wr(1, 0);
    wr(0, RUN);
    repeat (6) @(negedge clk);
    chk("R2 every third", count, 66);
    wr(0, 0);
    chk("R2 seventh tick", count, 76);
  endtask

  task automatic t_corr_every;
    wr(3, 1); wr(1, 0);
    wr(0, RUN);
    repeat (4) @(negedge clk);
    wr(0, 0);
    chk("R2 N=1", count, 65);
  endtask

  task automatic t_corr_restart;
    wr(3, 3); wr(1, 0);
    wr(0, RUN);
    @(negedge clk);
    wr(0, 0);
    chk("R8 two ticks", count, 20);
    wr(3, 3); wr(1, 0);
    wr(0, RUN);
    wr(0, 0);
    chk("R8 restart", count, 10);
  endtask

  task automatic t_period_wrap;
    wr(3, 0); wr(2, 32'd30); wr(4, 100); wr(1, 0);
    wr(0, RUN | EVT | PRST | OVF);
    repeat (3) @(negedge clk);
    chk("R3 pre-wrap", count, 90);
    chk("R4 no early pulse", {31'b0, wrap}, 0);
    @(negedge clk);
    chk("R3 remainder kept", count, 20);
    chk("R4 wrap pulse", {31'b0, wrap}, 1);
    chk("R7 ovf pulse", {31'b0, ovf}, 1);
    @(negedge clk);
    chk("R3 after wrap", count, 50);
    chk("R4 one cycle", {31'b0, wrap}, 0);
    chk("R7 one cycle", {31'b0, ovf}, 0);
    wr(0, 0);
    chk("R1 stop", count, 80);
  endtask

  task automatic t_natural_wrap;
    wr(2, 32'd20); wr(1, 32'hFFFF_FFF0);
    wr(0, RUN | EVT);
    @(negedge clk);
    chk("R3 full width", count, 4);
    chk("R4 natural wrap pulse", {31'b0, wrap}, 1);
    chk("R7 gated off", {31'b0, ovf}, 0);
    wr(0, 0);
    wr(1, 90);
    wr(0, RUN | EVT);
    @(negedge clk);
    chk("R3 period ignored", count, 110);
    chk("R4 no wrap", {31'b0, wrap}, 0);
    wr(0, 0);
  endtask

  task automatic t_wide_period;
    wr(2, 32'd10); wr(4, 32'h8000_0000); wr(1, 32'h7FFF_FFF8);
    wr(0, RUN | PRST);
    @(negedge clk);
    chk("R3 31-bit period", count, 2);
    chk("R4 gated off", {31'b0, wrap}, 0);
    wr(0, 0);
  endtask

  task automatic t_capture;
    logic [31:0] d;
    wr(2, 32'd10); wr(1, 1234);
    wr(0, RUN | CAP);
    rd(0, d); chk("R5 flag set", d & CAP, CAP);
    @(negedge clk);
    rd(0, d); chk("R5 flag second cycle", d & CAP, CAP);
    @(negedge clk);
    rd(0, d); chk("R5 flag cleared", d & CAP, 0);
    rd(1, d); chk("R5 snapshot", d, 1234);
    chk("R5 live moved", count, 1254);
    wr(0, 0);
    rd(1, d); chk("R5 snapshot stable", d, 1234);
  endtask

  task automatic t_load_running;
    wr(2, 32'd10); wr(1, 0);
    wr(0, RUN);
    @(negedge clk);
    wr(1, 5000);
    chk("R6 load wins", count, 5000);
    @(negedge clk);
    chk("R6 counts on", count, 5010);
    wr(0, 0);
  endtask

  initial begin
    #(200000 * 20);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_step_readback();
    t_basic();
    t_corr();
    t_corr_every();
    t_corr_restart();
    t_period_wrap();
    t_natural_wrap();
    t_wide_period();
    t_capture();
    t_load_running();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule